// File: doc/BRIEF.md
# Seven-Level Phase-Opposition Sinusoidal PWM Gate Generator

This block drives the six switches of a seven-level, six-switch inverter leg. A single clock-enable divider steps a triangular carrier phase. Each completed carrier period advances the index into a sine-shaped magnitude table. The table covers one half of the reference period, and a half flag toggles each time the table wraps. The same triangle serves as three stacked carriers in the positive band, one per level band. In the negative band the three stacked carriers use the inverted triangle, which places them 180 degrees out of phase with the positive set.

Comparing the table magnitude against the three carriers of the active band gives three SPWM signals in thermometer form. The other bank of three is held low. A fixed decode turns the active bank into six gate signals, with at most three switches on at any time. The block also reports a signed level code so that the staircase can be observed. Every output is registered, and deasserting enable turns all gates off at the next clock edge.

Top module: `pod7_gate_gen`

## Requirements
- R1: During reset and right after it, all gates and SPWM outputs are 0, the level code is 0 and the half flag is 0. The first enabled cycle reports table index 0 of the positive half with triangle value 0.
- R2: The carrier advances one step every DIV = CLK_HZ/(CARRIER_HZ*2*CAR_MAX) enabled clocks. The phase p runs from 0 to 2*CAR_MAX-1, and the triangle value is p when p <= CAR_MAX and 2*CAR_MAX-p otherwise. The table index advances once per carrier period and wraps after N = CARRIER_HZ/(2*REF_HZ) entries. The half flag (output neg_half_o, 1 = negative half) toggles at each wrap.
- R3: The table entry at index k is floor(4*3*CAR_MAX*k*(N-k)/(N*N)).
- R4: In the positive half, spwm_o[j] (j = 0..2) is 1 exactly when magnitude > j*CAR_MAX + triangle, and spwm_o[5:3] are 0.
- R5: In the negative half, spwm_o[3+j] is 1 exactly when magnitude > j*CAR_MAX + (CAR_MAX - triangle), and spwm_o[2:0] are 0.
- R6: In the positive half, gate bits 2 and 5 are 1 and gate bits 3 and 4 are 0. Gate bit 0 = spwm_o[1] AND NOT spwm_o[2], and gate bit 1 = spwm_o[2]. Gate bit i drives switch i+1.
- R7: In the negative half, gate bits 3 and 4 are 1 and gate bits 2 and 5 are 0. Gate bit 0 = spwm_o[4] AND NOT spwm_o[5], and gate bit 1 = spwm_o[5].
- R8: No more than three gate bits are 1 in any cycle.
- R9: level_o is a two's complement 3-bit value. Its magnitude is the number of active-bank SPWM bits that are 1. It is positive in the positive half, negative in the negative half, and 0 when no active-bank bit is set.
- R10: With en_i low at a clock edge, gates, SPWM bits and the level code are 0 after that edge and the half flag holds. The carrier and table state freeze and resume from the same point when en_i returns.
- R11: A 10 kHz carrier is selected by parameter alone, which changes DIV and N as given in R2.
- R12: The outputs after an enabled edge reflect the carrier state that was present before that edge, which is one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low forces all gates off |
| gate_o | output | 6 | Switch gate drives, bit i for switch i+1 |
| spwm_o | output | 6 | Intermediate SPWM signals, [2:0] positive bank, [5:3] negative bank |
| neg_half_o | output | 1 | 1 while the negative half cycle is output |
| level_o | output | 3 | Signed output level code, -3 to +3 |

## Verification
The bench builds two instances with CAR_MAX = 4. The first uses a 16 kHz carrier with DIV = 1 and N = 160. The second uses a 10 kHz carrier with DIV = 2 and N = 100. These small settings make a full reference period only 2560 and 3200 clocks long. Every clock of more than one period is compared against arithmetic expectations, which covers every table index, every triangle value, both band polarities, both half-cycle wraps and enable drops in each half.

// File: rtl/pod7_pkg.sv
package pod7_pkg;
    localparam int NUM_SW    = 6;
    localparam int NUM_BANDS = 3;

    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    // registered output bundle of the top
    typedef struct packed {
        logic [NUM_SW-1:0]    gate;
        logic [NUM_SW-1:0]    spwm;
        logic signed [2:0]    level;
        logic                 half;
    } out_s;
endpackage

// File: rtl/pod7_timebase.sv
module pod7_timebase #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int CARRIER_HZ = 16_000,
    parameter int REF_HZ     = 50,
    parameter int CAR_MAX    = 125,
    localparam int DIV       = CLK_HZ / (CARRIER_HZ * 2 * CAR_MAX),
    localparam int N_ENT     = CARRIER_HZ / (2 * REF_HZ),
    localparam int DW        = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int PW        = $clog2(2 * CAR_MAX),
    localparam int IW        = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int TW        = $clog2(CAR_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    output logic [IW-1:0] idx_o,
    output logic [TW-1:0] tri_o,
    output logic          half_o
);
    typedef struct packed {
        logic [DW-1:0] div;
        logic [PW-1:0] ph;
        logic [IW-1:0] idx;
        logic          half;
    } tb_s;

    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
    localparam logic [PW-1:0] PH_LAST  = PW'(2 * CAR_MAX - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(N_ENT - 1);

    tb_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_i) begin
            if (s_q.div == DIV_LAST) begin
                s_d.div = '0;
                if (s_q.ph == PH_LAST) begin
                    s_d.ph = '0;
                    if (s_q.idx == IDX_LAST) begin
                        s_d.idx  = '0;
                        s_d.half = ~s_q.half;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    // triangle folded from the phase: rises to CAR_MAX then falls
    always_comb begin
        int p;
        p     = int'(s_q.ph);
        tri_o = TW'((p <= CAR_MAX) ? p : (2 * CAR_MAX - p));
    end

    assign idx_o  = s_q.idx;
    assign half_o = s_q.half;

    always_ff @(posedge clk_i) begin
        if (!rst_i) begin
            assert_idx_range_R2: assert ({1'b0, s_q.idx} < (IW+1)'(N_ENT))
                else $error("table index out of range");
        end
    end

    assert_half_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(s_q.half) |-> (s_q.idx == '0 && s_q.ph == '0 && s_q.div == '0))
        else $error("half flag toggled away from a table wrap");

    assert_frozen_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(s_q))
        else $error("timebase moved while disabled");
endmodule

// File: rtl/pod7_sine_rom.sv
module pod7_sine_rom #(
    parameter int N_ENT = 160,
    parameter int AMP   = 375,
    parameter int IW    = 8,
    parameter int AW    = 9
) (
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] mag_o
);
    logic [AW-1:0] rom [N_ENT];

    // parabolic half-sine: 4*AMP*k*(N-k)/N^2, peak AMP at the midpoint
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        localparam longint VAL = (longint'(4) * AMP * k * (N_ENT - k)) / (longint'(N_ENT) * N_ENT);
        assign rom[k] = AW'(VAL);
    end

    always_comb begin
        mag_o = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if ({1'b0, idx_i} == (IW+1)'(k)) mag_o = rom[k];
        end
    end
endmodule

// File: rtl/pod7_decode.sv
module pod7_decode
    import pod7_pkg::*;
#(
    parameter int CAR_MAX = 125,
    parameter int AW      = 9,
    parameter int TW      = 7
) (
    input  logic [AW-1:0]     mag_i,
    input  logic [TW-1:0]     tri_i,
    input  logic              half_i,
    output logic [NUM_SW-1:0] spwm_o,
    output logic [NUM_SW-1:0] gate_o,
    output logic signed [2:0] level_o
);
    logic [NUM_BANDS-1:0] pos_cmp, neg_cmp, act;
    half_e                half;
    logic signed [2:0]    lv_mag;

    assign half = half_e'(half_i);

    // stacked carriers: positive set uses the triangle, negative set its inverse
    for (genvar j = 0; j < NUM_BANDS; j++) begin : g_band
        assign pos_cmp[j] = int'(mag_i) > (j * CAR_MAX + int'(tri_i));
        assign neg_cmp[j] = int'(mag_i) > (j * CAR_MAX + (CAR_MAX - int'(tri_i)));
    end

    always_comb begin
        gate_o = '0;
        if (half == HALF_NEG) begin
            act    = neg_cmp;
            spwm_o = {neg_cmp, 3'b000};
            gate_o[3] = 1'b1;
            gate_o[4] = 1'b1;
        end else begin
            act    = pos_cmp;
            spwm_o = {3'b000, pos_cmp};
            gate_o[2] = 1'b1;
            gate_o[5] = 1'b1;
        end
        gate_o[0] = act[1] & ~act[2];
        gate_o[1] = act[2];
        lv_mag    = {1'b0, 2'($countones(act))};
        level_o   = (half == HALF_NEG) ? -lv_mag : lv_mag;
    end

    always_comb begin
        assert_thermo_R4: assert (!(act[2] && !act[1]) && !(act[1] && !act[0]))
            else $error("comparator outputs not in thermometer order");
    end
endmodule

// File: rtl/pod7_gate_gen.sv
module pod7_gate_gen
    import pod7_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int CARRIER_HZ = 16_000,
    parameter int REF_HZ     = 50,
    parameter int CAR_MAX    = 125
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic [5:0]        gate_o,
    output logic [5:0]        spwm_o,
    output logic              neg_half_o,
    output logic signed [2:0] level_o
);
    localparam int N_ENT = CARRIER_HZ / (2 * REF_HZ);
    localparam int AMP   = 3 * CAR_MAX;
    localparam int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int TW    = $clog2(CAR_MAX + 1);
    localparam int AW    = $clog2(AMP + 1);

    logic [IW-1:0]     idx;
    logic [TW-1:0]     tri_v;
    logic              half;
    logic [AW-1:0]     mag;
    logic [5:0]        dec_spwm, dec_gate;
    logic signed [2:0] dec_level;

    out_s out_d, out_q;

    pod7_timebase #(
        .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .REF_HZ(REF_HZ), .CAR_MAX(CAR_MAX)
    ) u_tb (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
        .idx_o(idx), .tri_o(tri_v), .half_o(half)
    );

    pod7_sine_rom #(.N_ENT(N_ENT), .AMP(AMP), .IW(IW), .AW(AW)) u_rom (
        .idx_i(idx), .mag_o(mag)
    );

    pod7_decode #(.CAR_MAX(CAR_MAX), .AW(AW), .TW(TW)) u_dec (
        .mag_i(mag), .tri_i(tri_v), .half_i(half),
        .spwm_o(dec_spwm), .gate_o(dec_gate), .level_o(dec_level)
    );

    always_comb begin
        out_d = out_q;
        if (en_i) begin
            out_d.gate  = dec_gate;
            out_d.spwm  = dec_spwm;
            out_d.level = dec_level;
            out_d.half  = half;
        end else begin
            out_d.gate  = '0;
            out_d.spwm  = '0;
            out_d.level = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign gate_o     = out_q.gate;
    assign spwm_o     = out_q.spwm;
    assign neg_half_o = out_q.half;
    assign level_o    = out_q.level;

    assert_max_three_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(gate_o) <= 3)
        else $error("more than three switches on");

    assert_off_when_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (gate_o == '0 && spwm_o == '0 && level_o == '0))
        else $error("outputs active after enable dropped");

    assert_bank_split_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !((|spwm_o[2:0]) && (|spwm_o[5:3])))
        else $error("both SPWM banks active");

    assert_pos_pair_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_o != '0 && !neg_half_o) |-> (gate_o[2] && gate_o[5] && !gate_o[3] && !gate_o[4]))
        else $error("positive half switch pair wrong");

    assert_neg_pair_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_o != '0 && neg_half_o) |-> (gate_o[3] && gate_o[4] && !gate_o[2] && !gate_o[5]))
        else $error("negative half switch pair wrong");

    assert_level_sign_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_o != '0) |-> ((level_o < 0) == neg_half_o))
        else $error("level sign disagrees with half flag");
endmodule

// File: tb/pod7_gate_gen_test.sv
module pod7_gate_gen_test;
    localparam int C  = 4;
    localparam int NA = 160;
    localparam int DA = 1;
    localparam int NB = 100;
    localparam int DB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    always #2.5 clk = ~clk;

    logic [5:0] ga, sa, gb, sb;
    logic       ha, hb;
    logic signed [2:0] la, lb;

    pod7_gate_gen #(.CLK_HZ(128_000), .CARRIER_HZ(16_000), .REF_HZ(50), .CAR_MAX(C)) uut (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .gate_o(ga), .spwm_o(sa), .neg_half_o(ha), .level_o(la)
    );

    // R11: same block with a 10 kHz carrier chosen only by parameter
    pod7_gate_gen #(.CLK_HZ(160_000), .CARRIER_HZ(10_000), .REF_HZ(50), .CAR_MAX(C)) uut_b (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .gate_o(gb), .spwm_o(sb), .neg_half_o(hb), .level_o(lb)
    );

    int  vectors = 0;
    int  miscompares = 0;
    int  e = 0;
    bit  done = 1'b0;
    bit  last_ha = 1'b0, last_hb = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected outputs from the requirement formulas for tick count t
    task automatic model(input int t, input int n, output logic [5:0] sp,
                         output logic [5:0] g, output int lvl, output bit hf);
        int p, tr, k, m, cnt;
        bit [2:0] act;
        p   = t % (2 * C);
        tr  = (p <= C) ? p : 2 * C - p;               // R2
        k   = (t / (2 * C)) % n;
        hf  = ((t / (2 * C * n)) % 2) == 1;
        m   = (4 * 3 * C * k * (n - k)) / (n * n);    // R3
        for (int j = 0; j < 3; j++)
            act[j] = hf ? (m > j * C + (C - tr)) : (m > j * C + tr);
        sp  = hf ? {act, 3'b000} : {3'b000, act};
        g   = 6'b0;
        if (hf) begin g[3] = 1'b1; g[4] = 1'b1; end
        else    begin g[2] = 1'b1; g[5] = 1'b1; end
        g[0] = act[1] & ~act[2];
        g[1] = act[2];
        cnt = int'(act[0]) + int'(act[1]) + int'(act[2]);
        lvl = hf ? -cnt : cnt;
    endtask

    task automatic check_inst(input string pre, input int n, input int d, input bit on,
                              input logic [5:0] sp, input logic [5:0] g,
                              input logic signed [2:0] lv, input logic hf, inout bit last_hf);
        logic [5:0] esp, eg;
        int elv;
        bit ehf;
        if (on) begin
            // R12: output after edge e reflects state after e-1 enabled edges
            model((e - 1) / d, n, esp, eg, elv, ehf);
            chk(sp == esp, {pre, ehf ? "R5 spwm" : "R4/R3 spwm"}, int'(sp), int'(esp));
            chk(g == eg, {pre, ehf ? "R7 gate" : "R6 gate"}, int'(g), int'(eg));
            chk(int'(lv) == elv, {pre, "R9 level"}, int'(lv), elv);
            chk(hf == ehf, {pre, "R2 half"}, int'(hf), int'(ehf));
            chk($countones(g) <= 3, {pre, "R8 count"}, $countones(g), 3);
            last_hf = ehf;
        end else begin
            chk(g == 6'b0 && sp == 6'b0 && lv == 3'sd0, {pre, "R10 idle"},
                int'({g, sp}), 0);
            chk(hf == last_hf, {pre, "R10 half hold"}, int'(hf), int'(last_hf));
        end
    endtask

    task automatic step(input bit on);
        en = on;
        @(posedge clk);
        #1;
        if (on) e++;
        check_inst("",     NA, DA, on, sa, ga, la, ha, last_ha);
        check_inst("R11 ", NB, DB, on, sb, gb, lb, hb, last_hb);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(ga == 0 && sa == 0 && la == 0 && ha == 0, "R1 reset A", int'({ga, sa}), 0);
        chk(gb == 0 && sb == 0 && lb == 0 && hb == 0, "R1 reset B", int'({gb, sb}), 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: first enabled cycle is index 0, positive half, triangle 0
        step(1'b1);
        chk(ga == 6'b100100 && la == 0, "R1 first cycle", int'(ga), 36);
        for (int i = 0; i < 700; i++) step(1'b1);
        for (int i = 0; i < 5; i++) step(1'b0);   // R10 in positive half
        for (int i = 0; i < 2600; i++) step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);   // R10 around negative half
        for (int i = 0; i < 3300; i++) step(1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200_000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule